// File: doc/BRIEF.md
# Prioritized Encoded Interrupt Controller

The block gathers up to sixteen interrupt request lines from devices and hands them to a processor one at a time. It presents the winning request as a 4-bit encoded line number together with a pending flag. A rising edge on a request line records a latched request for that line. The processor takes the offered request with a one-cycle acknowledge, and signals the end of a handler with a one-cycle end-of-service pulse.

A mask register can disable individual lines. A request that arrives on a disabled line is kept, not dropped, and is offered once the line is enabled again. Priority is fixed: line 0 is the most urgent and line 15 the least. An in-service vector records the levels whose handlers are running. A new request is offered only if it outranks every running level, so a more urgent request can nest over a running handler. Requests of the same or lower priority wait until the running level ends.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq_pend` is 0, `irq_id` is 0, no line is latched, no level is in service, and all lines are enabled (mask all zeros).
- R2: A 0-to-1 transition on `irq_req[i]` latches a request for line i, and `irq_pend` rises two clock edges later with `irq_id` = i. A line held high does not latch again after its request has been taken.
- R3: Setting `mask[i]`=1, written through `mask_we`/`mask_wdata`, keeps line i from being offered. Its latched request is retained and is offered after the line is unmasked.
- R4: When several enabled lines are latched, the line with the lowest index is offered.
- R5: `irq_pend` is 1 only when the offered line has a strictly lower index than every line in service. A request whose priority equals or falls below a running level waits.
- R6: A request of higher priority than every running level is offered while those levels are still in service, so handlers nest.
- R7: While `irq_pend` is 1 and `irq_ack` is 0, `irq_pend` stays 1 and `irq_id` does not change, even if a more urgent request arrives in the meantime.
- R8: `irq_ack` while `irq_pend` is 1 clears the latched request of line `irq_id` and marks that line in service. `irq_pend` is 0 in the following cycle, so requests are offered strictly one after another.
- R9: An `irq_eos` pulse removes only the most urgent (lowest-index) in-service level.
- R10: `irq_ack` while `irq_pend` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 16 | Device request lines, edge sensitive |
| mask_we | input | 1 | Load `mask_wdata` into the mask register |
| mask_wdata | input | 16 | New mask; bit i = 1 disables line i |
| irq_ack | input | 1 | Processor takes the offered request |
| irq_eos | input | 1 | End of service of the most urgent running level |
| irq_pend | output | 1 | A request is being offered |
| irq_id | output | 4 | Encoded number of the offered line |

## Verification
The assertions check on every cycle that an offered number stays stable until acknowledge, that `irq_pend` falls right after an acknowledge, and that an offered line never collides with an equal or more urgent in-service level. They also check that a newly offered line was latched and unmasked, that end-of-service removes exactly one level, and that a stray acknowledge leaves the in-service state alone. The priority order among simultaneous requests, the retention of masked requests over many cycles, nesting followed by unwinding in the right order, and the rule that a held-high line does not latch again can only be shown by the bench's scenarios, which observe these through the offered numbers.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned MAX_LINES = 32;
  typedef logic [MAX_LINES-1:0] line_vec_t;

  // Index of the least significant set bit; MAX_LINES when none is set.
  function automatic int unsigned lowest_set(line_vec_t v);
    int unsigned r;
    r = MAX_LINES;
    for (int i = MAX_LINES - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  function automatic line_vec_t onehot(int unsigned idx);
    return line_vec_t'(1) << idx;
  endfunction
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_in,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] pend_vec,
  output logic [N-1:0] rise_vec
);
  logic [N-1:0] req_q;

  assign rise_vec = req_in & ~req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= '0;
      pend_vec <= '0;
    end else begin
      req_q    <= req_in;
      // a fresh edge wins over a clear in the same cycle
      pend_vec <= (pend_vec & ~clr_vec) | rise_vec;
    end
  end
endmodule

// File: rtl/irq_isr_track.sv
module irq_isr_track
  import irq_ctrl_pkg::*;
#(
  parameter int N    = 16,
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [ID_W-1:0] take_id,
  input  logic            eos,
  output logic [N-1:0]    isr_vec,
  output logic            isr_any,
  output logic [ID_W-1:0] isr_top
);
  logic [N-1:0] set_vec;
  logic [N-1:0] drop_vec;

  assign isr_any  = |isr_vec;
  assign isr_top  = ID_W'(lowest_set(line_vec_t'(isr_vec)));
  assign set_vec  = take ? N'(onehot(int'(take_id))) : '0;
  assign drop_vec = (eos && isr_any) ? N'(onehot(int'(isr_top))) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) isr_vec <= '0;
    else        isr_vec <= (isr_vec & ~drop_vec) | set_vec;
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage
  import irq_ctrl_pkg::*;
#(
  parameter int N    = 16,
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    cand_vec,
  input  logic            isr_any,
  input  logic [ID_W-1:0] isr_top,
  input  logic            ack,
  output logic            out_valid,
  output logic [ID_W-1:0] out_id,
  output logic            take,
  output logic            win
);
  logic            cand_any;
  logic [ID_W-1:0] best_id;

  assign cand_any = |cand_vec;
  assign best_id  = ID_W'(lowest_set(line_vec_t'(cand_vec)));
  assign win      = cand_any && (!isr_any || (best_id < isr_top));
  assign take     = out_valid && ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_id    <= '0;
    end else if (out_valid) begin
      if (ack) out_valid <= 1'b0;
    end else if (win) begin
      out_valid <= 1'b1;
      out_id    <= best_id;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int N_LINES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_LINES-1:0]         irq_req,
  input  logic                       mask_we,
  input  logic [N_LINES-1:0]         mask_wdata,
  input  logic                       irq_ack,
  input  logic                       irq_eos,
  output logic                       irq_pend,
  output logic [$clog2(N_LINES)-1:0] irq_id
);
  localparam int ID_W = $clog2(N_LINES);

  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] pend_vec;
  logic [N_LINES-1:0] rise_vec;
  logic [N_LINES-1:0] clr_vec;
  logic [N_LINES-1:0] cand_vec;
  logic [N_LINES-1:0] isr_vec;
  logic               isr_any;
  logic [ID_W-1:0]    isr_top;
  logic               take;
  logic               win;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  assign clr_vec  = take ? N_LINES'(onehot(int'(irq_id))) : '0;
  assign cand_vec = pend_vec & ~mask_q;

  irq_edge_latch #(.N(N_LINES)) u_latch (
    .clk(clk), .rst_n(rst_n), .req_in(irq_req), .clr_vec(clr_vec),
    .pend_vec(pend_vec), .rise_vec(rise_vec)
  );

  irq_isr_track #(.N(N_LINES), .ID_W(ID_W)) u_isr (
    .clk(clk), .rst_n(rst_n), .take(take), .take_id(irq_id), .eos(irq_eos),
    .isr_vec(isr_vec), .isr_any(isr_any), .isr_top(isr_top)
  );

  irq_out_stage #(.N(N_LINES), .ID_W(ID_W)) u_out (
    .clk(clk), .rst_n(rst_n), .cand_vec(cand_vec), .isr_any(isr_any),
    .isr_top(isr_top), .ack(irq_ack), .out_valid(irq_pend), .out_id(irq_id),
    .take(take), .win(win)
  );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N    = 16,
  parameter int ID_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_pend,
  input logic [ID_W-1:0] irq_id,
  input logic            irq_ack,
  input logic            irq_eos,
  input logic [N-1:0]    mask_q,
  input logic [N-1:0]    pend_vec,
  input logic [N-1:0]    isr_vec
);
  logic [N-1:0] mask_d;
  logic [N-1:0] pend_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_d <= '0;
      pend_d <= '0;
    end else begin
      mask_d <= mask_q;
      pend_d <= pend_vec;
    end
  end

  // true when some running level is as urgent as, or more urgent than, id
  function automatic logic blocked_by(logic [N-1:0] isr, logic [ID_W-1:0] id);
    logic b;
    b = 1'b0;
    for (int j = 0; j < N; j++) begin
      if (isr[j] && (j <= int'(id))) b = 1'b1;
    end
    return b;
  endfunction

  // R7
  held_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !irq_ack) |=> (irq_pend && $stable(irq_id)));

  // R8
  one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && irq_ack) |=> !irq_pend);

  // R5
  outranks_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> !blocked_by(isr_vec, irq_id));

  // R3
  offered_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> (!mask_d[irq_id] && pend_d[irq_id]));

  // R9
  eos_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_eos && !(irq_pend && irq_ack) && (isr_vec != '0))
      |=> ($countones(isr_vec) + 1 == $past($countones(isr_vec))));

  // R10
  stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_pend && !irq_eos) |=> $stable(isr_vec));
endmodule

bind irq_prio_ctrl irq_ctrl_chk #(.N(N_LINES), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_id(irq_id),
  .irq_ack(irq_ack), .irq_eos(irq_eos), .mask_q(mask_q),
  .pend_vec(pend_vec), .isr_vec(isr_vec)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_req = '0;
  logic        mask_we = 1'b0;
  logic [15:0] mask_wdata = '0;
  logic        irq_ack = 1'b0;
  logic        irq_eos = 1'b0;
  logic        irq_pend;
  logic [3:0]  irq_id;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl #(.N_LINES(16)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .irq_ack(irq_ack), .irq_eos(irq_eos),
    .irq_pend(irq_pend), .irq_id(irq_id)
  );

  // advance n edges, then sit 2 ns past the last one
  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_offer(string req, int id);
    check(req, int'(irq_pend), 1);
    check(req, int'(irq_id), id);
  endtask

  task automatic do_ack();
    irq_ack = 1'b1; step(1); irq_ack = 1'b0;
  endtask

  task automatic do_eos();
    irq_eos = 1'b1; step(1); irq_eos = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 pend", int'(irq_pend), 0);
    check("R1 id", int'(irq_id), 0);
  endtask

  task automatic t_stray_ack();
    do_ack();                       // nothing offered: ignored
    step(1);
    check("R10 no offer", int'(irq_pend), 0);
    irq_req[6] = 1'b1; step(2);
    expect_offer("R10 line6 not blocked", 6);
    do_ack(); do_eos();
    irq_req[6] = 1'b0; step(1);
  endtask

  task automatic t_single();
    irq_req[5] = 1'b1; step(2);
    expect_offer("R2 edge", 5);
    step(3);
    expect_offer("R7 held", 5);
    do_ack();
    check("R8 drop", int'(irq_pend), 0);
    step(3);
    check("R2 level no retrigger", int'(irq_pend), 0);
    irq_req[9] = 1'b1; step(3);
    check("R5 lower waits", int'(irq_pend), 0);
    do_eos(); step(1);
    expect_offer("R9 after eos", 9);
    do_ack(); do_eos();
    irq_req[5] = 1'b0; irq_req[9] = 1'b0; step(1);
  endtask

  task automatic t_priority();
    irq_req[3] = 1'b1; irq_req[7] = 1'b1; irq_req[12] = 1'b1; step(2);
    expect_offer("R4 lowest index", 3);
    do_ack(); step(2);
    check("R5 lower than running", int'(irq_pend), 0);
    do_eos(); step(1);
    expect_offer("R4 second", 7);
    do_ack(); do_eos(); step(1);
    expect_offer("R4 third", 12);
    do_ack(); do_eos();
    irq_req = '0; step(2);
    check("R8 all served", int'(irq_pend), 0);
  endtask

  task automatic t_nest();
    irq_req[10] = 1'b1; step(2);
    expect_offer("R6 base", 10);
    do_ack();
    irq_req[2] = 1'b1; step(2);
    expect_offer("R6 nested", 2);
    do_ack();
    do_eos();                       // removes level 2 only
    irq_req[10] = 1'b0; step(1);
    irq_req[10] = 1'b1; step(3);
    check("R9 level10 still running", int'(irq_pend), 0);
    do_eos(); step(1);
    expect_offer("R9 level10 released", 10);
    do_ack(); do_eos();
    irq_req = '0; step(1);
  endtask

  task automatic t_mask();
    mask_wdata = 16'h0010; mask_we = 1'b1; step(1); mask_we = 1'b0;
    irq_req[4] = 1'b1; step(4);
    check("R3 masked", int'(irq_pend), 0);
    irq_req[4] = 1'b0; step(3);
    check("R3 still masked", int'(irq_pend), 0);
    mask_wdata = 16'h0000; mask_we = 1'b1; step(1); mask_we = 1'b0;
    step(1);
    expect_offer("R3 kept and delivered", 4);
    do_ack(); do_eos(); step(1);
  endtask

  task automatic t_hold();
    irq_req[8] = 1'b1; step(2);
    expect_offer("R7 first", 8);
    irq_req[1] = 1'b1; step(3);
    expect_offer("R7 not replaced", 8);
    do_ack();
    check("R8 gap", int'(irq_pend), 0);
    step(1);
    expect_offer("R6 preempt", 1);
    do_ack(); do_eos(); do_eos();
    irq_req = '0; step(2);
    check("R9 unwound", int'(irq_pend), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_stray_ack();
    t_single();
    t_priority();
    t_nest();
    t_mask();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule